// File: doc/BRIEF.md
# Condition Indicators and Next-Address Sequencer

This block keeps the six condition indicators of a 16-bit accumulator machine and owns the instruction address register. The indicators are positive, negative, zero, even, carry and overflow. Whenever the datapath writes the accumulator, it presents the new value to the block. The block then derives positive, negative, zero and even from that value. It also merges the arithmetic unit's carry and overflow outputs into two sticky flags.

On each cycle the sequencer receives one command. The command advances the address past a one-word or two-word instruction, evaluates a conditional transfer against a six-bit indicator mask, settles a modify-index-and-skip, or jumps without a condition. A conditional transfer in skip form moves the address forward by exactly one word, on the assumption that the next instruction is one word long. In branch form it loads the effective address. The modify-index case skips when the index value changes sign or becomes zero. It does not test the indicators. The arithmetic itself and all memory traffic stay outside the block. The block receives the index value before and after modification, and it receives the effective address already formed.

Top module: `cond_seq_unit`

## Requirements
- R1: After synchronous reset, `iar` equals parameter `RST_IAR` (default 0), `ind` reads 6'b001100 (zero and even set, all others clear) and `taken` is 0.
- R2: One cycle after `acc_wr`, the indicator bits follow the value written. Bit 0 (positive) is set when the value is nonzero and its bit 15 is 0. Bit 1 (negative) is set when bit 15 is 1. Bit 2 (zero) is set when all 16 bits are 0. Bit 3 (even) is set when bit 0 of the value is 0.
- R3: Without `acc_wr`, `ind[3:0]` keep their values whatever the command.
- R4: `ind[4]` (carry) and `ind[5]` (overflow) are set one cycle after an `acc_wr` cycle in which `alu_carry` or `alu_ovf` respectively is 1. They stay set through later accumulator writes whose flag inputs are 0.
- R5: `stat_ld` writes `stat_cv[0]` into carry and `stat_cv[1]` into overflow. This write takes priority over any set or clear in the same cycle.
- R6: Command 3 (skip) adds 1 to `iar` when any indicator selected by `mask` is 1. Otherwise `iar` is unchanged. Mask bit n selects `ind[n]`, and the decision uses the indicator values held before that cycle.
- R7: Command 4 (branch) loads `iar` with `ea` when any masked indicator is 1. Otherwise `iar` is unchanged.
- R8: Commands 3 and 4 clear carry and overflow when the corresponding mask bit (4 or 5) is 1. This happens whether or not the transfer is taken. An indicator that is not masked is left as it was.
- R9: Command 5 (modify-index skip) adds 1 to `iar` when bit 15 of `mdx_new` differs from bit 15 of `mdx_old`, or when `mdx_new` is 0. Otherwise `iar` is unchanged.
- R10: Command 1 adds 1 and command 2 adds 2 to the 15-bit `iar`, wrapping modulo 2^15. Commands 0 and 7 leave `iar` unchanged.
- R11: Command 6 (jump) loads `iar` with `ea` unconditionally.
- R12: `taken` is 1 in the cycle after a command 3, 4 or 5 whose condition held, or after a command 6. It is 0 after every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd | input | 3 | Sequencer command: 0 idle, 1 step one word, 2 step two words, 3 skip, 4 branch, 5 modify-index skip, 6 jump |
| mask | input | 6 | Indicator select for commands 3 and 4 |
| ea | input | 15 | Effective address for branch and jump |
| mdx_old | input | 16 | Index value before modification |
| mdx_new | input | 16 | Index value after modification |
| acc_wr | input | 1 | Accumulator written this cycle |
| acc_val | input | 16 | Value written to the accumulator |
| alu_carry | input | 1 | Carry out of the arithmetic unit for this write |
| alu_ovf | input | 1 | Overflow out of the arithmetic unit for this write |
| stat_ld | input | 1 | Load carry and overflow from a status word |
| stat_cv | input | 2 | Status bits: bit 0 carry, bit 1 overflow |
| iar | output | 15 | Instruction address register |
| ind | output | 6 | Indicators: 0 positive, 1 negative, 2 zero, 3 even, 4 carry, 5 overflow |
| taken | output | 1 | Last command transferred or skipped |

## Verification
Every indicator is a register that drives the `ind` port directly, so a wrong indicator shows on the port one cycle after the write that produced it. A corrupted sticky flag can also stay hidden until a later skip or branch tests it. The error then shows up as an `iar` that is off by one word or off by the distance to `ea`, and the bench watches for this on the following cycle. Errors in address arithmetic, wrap or priority show up on `iar` in the cycle after the command. A wrong clear-on-test becomes visible only through `ind` after that test, so the bench reads the flags back each time a masked test has run.

// File: rtl/cond_seq_pkg.sv
package cond_seq_pkg;

  localparam int IND_N   = 6;
  localparam int IX_POS  = 0;
  localparam int IX_NEG  = 1;
  localparam int IX_ZERO = 2;
  localparam int IX_EVEN = 3;
  localparam int IX_CRY  = 4;
  localparam int IX_OVF  = 5;

  typedef enum logic [2:0] {
    CMD_IDLE   = 3'd0,
    CMD_STEP1  = 3'd1,
    CMD_STEP2  = 3'd2,
    CMD_SKIP   = 3'd3,
    CMD_BRANCH = 3'd4,
    CMD_MDX    = 3'd5,
    CMD_JUMP   = 3'd6,
    CMD_RSVD   = 3'd7
  } seq_cmd_e;

  localparam logic [IND_N-1:0] STICKY_MASK = 6'b110000;

endpackage

// File: rtl/cond_flag_regs.sv
module cond_flag_regs
  import cond_seq_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc_wr,
  input  logic [DW-1:0]    acc_val,
  input  logic             alu_carry,
  input  logic             alu_ovf,
  input  logic             stat_ld,
  input  logic [1:0]       stat_cv,
  input  logic [IND_N-1:0] test_clr,
  output logic [IND_N-1:0] ind
);

  logic [IND_N-1:0] ind_q;
  logic             sgn;
  logic             is_zero;

  assign sgn     = acc_val[DW-1];
  assign is_zero = (acc_val == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      ind_q <= 6'b001100;
    end else begin
      if (acc_wr) begin
        ind_q[IX_POS]  <= ~sgn & ~is_zero;
        ind_q[IX_NEG]  <= sgn;
        ind_q[IX_ZERO] <= is_zero;
        ind_q[IX_EVEN] <= ~acc_val[0];
      end
      if (stat_ld) begin
        ind_q[IX_CRY] <= stat_cv[0];
        ind_q[IX_OVF] <= stat_cv[1];
      end else begin
        ind_q[IX_CRY] <= (ind_q[IX_CRY] & ~test_clr[IX_CRY]) | (acc_wr & alu_carry);
        ind_q[IX_OVF] <= (ind_q[IX_OVF] & ~test_clr[IX_OVF]) | (acc_wr & alu_ovf);
      end
    end
  end

  assign ind = ind_q;

endmodule

// File: rtl/cond_mask_test.sv
module cond_mask_test
  import cond_seq_pkg::*;
(
  input  logic [IND_N-1:0] ind,
  input  logic [IND_N-1:0] mask,
  output logic             hit
);

  logic [IND_N-1:0] sel;

  for (genvar g = 0; g < IND_N; g++) begin : g_sel
    assign sel[g] = ind[g] & mask[g];
  end

  assign hit = |sel;

endmodule

// File: rtl/mdx_skip_eval.sv
module mdx_skip_eval #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] old_val,
  input  logic [DW-1:0] new_val,
  output logic          skip
);

  logic sign_flip;
  logic now_zero;

  assign sign_flip = old_val[DW-1] ^ new_val[DW-1];
  assign now_zero  = (new_val == '0);
  assign skip      = sign_flip | now_zero;

endmodule

// File: rtl/iar_sequencer.sv
module iar_sequencer
  import cond_seq_pkg::*;
#(
  parameter int          AW      = 15,
  parameter logic [AW-1:0] RST_IAR = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  seq_cmd_e      cmd,
  input  logic          cond_hit,
  input  logic          mdx_skip,
  input  logic [AW-1:0] ea,
  output logic [AW-1:0] iar,
  output logic          taken
);

  logic [AW-1:0] iar_q;
  logic [AW-1:0] iar_d;
  logic          taken_d;
  logic [AW-1:0] plus1;
  logic [AW-1:0] plus2;

  assign plus1 = iar_q + AW'(1);
  assign plus2 = iar_q + AW'(2);

  always_comb begin
    iar_d   = iar_q;
    taken_d = 1'b0;
    unique case (cmd)
      CMD_STEP1:  iar_d = plus1;
      CMD_STEP2:  iar_d = plus2;
      CMD_SKIP: begin
        if (cond_hit) begin
          iar_d   = plus1;
          taken_d = 1'b1;
        end
      end
      CMD_BRANCH: begin
        if (cond_hit) begin
          iar_d   = ea;
          taken_d = 1'b1;
        end
      end
      CMD_MDX: begin
        if (mdx_skip) begin
          iar_d   = plus1;
          taken_d = 1'b1;
        end
      end
      CMD_JUMP: begin
        iar_d   = ea;
        taken_d = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      iar_q <= RST_IAR;
      taken <= 1'b0;
    end else begin
      iar_q <= iar_d;
      taken <= taken_d;
    end
  end

  assign iar = iar_q;

endmodule

// File: rtl/cond_seq_unit.sv
module cond_seq_unit
  import cond_seq_pkg::*;
#(
  parameter int            DW      = 16,
  parameter int            AW      = 15,
  parameter logic [AW-1:0] RST_IAR = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    cmd,
  input  logic [5:0]    mask,
  input  logic [AW-1:0] ea,
  input  logic [DW-1:0] mdx_old,
  input  logic [DW-1:0] mdx_new,
  input  logic          acc_wr,
  input  logic [DW-1:0] acc_val,
  input  logic          alu_carry,
  input  logic          alu_ovf,
  input  logic          stat_ld,
  input  logic [1:0]    stat_cv,
  output logic [AW-1:0] iar,
  output logic [5:0]    ind,
  output logic          taken
);

  seq_cmd_e         cmd_e;
  logic             is_test;
  logic [IND_N-1:0] clr_vec;
  logic             hit;
  logic             mdx_hit;

  assign cmd_e   = seq_cmd_e'(cmd);
  assign is_test = (cmd_e == CMD_SKIP) || (cmd_e == CMD_BRANCH);
  assign clr_vec = is_test ? (mask & STICKY_MASK) : '0;

  cond_flag_regs #(.DW(DW)) u_flags (
    .clk       (clk),
    .rst       (rst),
    .acc_wr    (acc_wr),
    .acc_val   (acc_val),
    .alu_carry (alu_carry),
    .alu_ovf   (alu_ovf),
    .stat_ld   (stat_ld),
    .stat_cv   (stat_cv),
    .test_clr  (clr_vec),
    .ind       (ind)
  );

  cond_mask_test u_test (
    .ind  (ind),
    .mask (mask),
    .hit  (hit)
  );

  mdx_skip_eval #(.DW(DW)) u_mdx (
    .old_val (mdx_old),
    .new_val (mdx_new),
    .skip    (mdx_hit)
  );

  iar_sequencer #(.AW(AW), .RST_IAR(RST_IAR)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .cmd      (cmd_e),
    .cond_hit (hit),
    .mdx_skip (mdx_hit),
    .ea       (ea),
    .iar      (iar),
    .taken    (taken)
  );

endmodule

// File: rtl/cond_seq_unit_chk.sv
module cond_seq_unit_chk #(
  parameter int DW = 16,
  parameter int AW = 15
) (
  input logic          clk,
  input logic          rst,
  input logic [2:0]    cmd,
  input logic [5:0]    mask,
  input logic [AW-1:0] ea,
  input logic [DW-1:0] mdx_old,
  input logic [DW-1:0] mdx_new,
  input logic          acc_wr,
  input logic [DW-1:0] acc_val,
  input logic          alu_carry,
  input logic          stat_ld,
  input logic [1:0]    stat_cv,
  input logic [AW-1:0] iar,
  input logic [5:0]    ind,
  input logic          taken
);

  logic any_sel;
  assign any_sel = |(ind & mask);

  a_r2_zero_follows: assert property (@(posedge clk) disable iff (rst)
    acc_wr |=> (ind[2] == ($past(acc_val) == '0)));

  a_r2_pos_neg_excl: assert property (@(posedge clk) disable iff (rst)
    !(ind[0] && ind[1]));

  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    !acc_wr |=> $stable(ind[3:0]));

  a_r4_carry_set: assert property (@(posedge clk) disable iff (rst)
    (acc_wr && alu_carry && !stat_ld) |=> ind[4]);

  a_r5_status_load: assert property (@(posedge clk) disable iff (rst)
    stat_ld |=> (ind[5:4] == $past(stat_cv)));

  a_r6_skip_taken: assert property (@(posedge clk) disable iff (rst)
    (cmd == 3'd3 && any_sel) |=> (iar == $past(iar) + AW'(1)));

  a_r7_branch_taken: assert property (@(posedge clk) disable iff (rst)
    (cmd == 3'd4 && any_sel) |=> (iar == $past(ea)));

  a_r6_not_taken: assert property (@(posedge clk) disable iff (rst)
    ((cmd == 3'd3 || cmd == 3'd4) && !any_sel) |=> $stable(iar));

  a_r8_cleared: assert property (@(posedge clk) disable iff (rst)
    ((cmd == 3'd3 || cmd == 3'd4) && mask[4] && !stat_ld && !acc_wr) |=> !ind[4]);

  a_r9_mdx_zero: assert property (@(posedge clk) disable iff (rst)
    (cmd == 3'd5 && mdx_new == '0) |=> (iar == $past(iar) + AW'(1)));

  a_r9_mdx_flip: assert property (@(posedge clk) disable iff (rst)
    (cmd == 3'd5 && (mdx_old[DW-1] != mdx_new[DW-1])) |=> taken);

  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (cmd == 3'd0) |=> (!taken && $stable(iar)));

endmodule

bind cond_seq_unit cond_seq_unit_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd       (cmd),
  .mask      (mask),
  .ea        (ea),
  .mdx_old   (mdx_old),
  .mdx_new   (mdx_new),
  .acc_wr    (acc_wr),
  .acc_val   (acc_val),
  .alu_carry (alu_carry),
  .stat_ld   (stat_ld),
  .stat_cv   (stat_cv),
  .iar       (iar),
  .ind       (ind),
  .taken     (taken)
);

// File: tb/cond_seq_unit_tb.sv
`timescale 1ns/1ps
module cond_seq_unit_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic [2:0]  cmd;
  logic [5:0]  mask;
  logic [14:0] ea;
  logic [15:0] mdx_old, mdx_new;
  logic        acc_wr;
  logic [15:0] acc_val;
  logic        alu_carry, alu_ovf, stat_ld;
  logic [1:0]  stat_cv;
  logic [14:0] iar;
  logic [5:0]  ind;
  logic        taken;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  cond_seq_unit u_dut (
    .clk(clk), .rst(rst), .cmd(cmd), .mask(mask), .ea(ea),
    .mdx_old(mdx_old), .mdx_new(mdx_new), .acc_wr(acc_wr), .acc_val(acc_val),
    .alu_carry(alu_carry), .alu_ovf(alu_ovf), .stat_ld(stat_ld), .stat_cv(stat_cv),
    .iar(iar), .ind(ind), .taken(taken)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    cmd = 3'd0; mask = '0; ea = '0; mdx_old = '0; mdx_new = '0;
    acc_wr = 0; acc_val = '0; alu_carry = 0; alu_ovf = 0; stat_ld = 0; stat_cv = '0;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    idle_inputs();
  endtask

  task automatic do_cmd(input logic [2:0] c, input logic [5:0] m, input logic [14:0] a);
    cmd = c; mask = m; ea = a;
    tick();
  endtask

  task automatic acc_write(input logic [15:0] v, input logic c, input logic o);
    acc_wr = 1; acc_val = v; alu_carry = c; alu_ovf = o;
    tick();
  endtask

  task automatic t_reset();
    chk("R1 iar", 16'(iar), 16'h0000);
    chk("R1 ind", 16'(ind), 16'h000C);
    chk("R1 taken", 16'(taken), 16'h0);
  endtask

  task automatic t_acc_values();
    acc_write(16'h0000, 0, 0); chk("R2 zero", 16'(ind), 16'h000C);
    acc_write(16'h8001, 0, 0); chk("R2 neg odd", 16'(ind), 16'h0002);
    acc_write(16'h0002, 0, 0); chk("R2 pos even", 16'(ind), 16'h0009);
    acc_write(16'h7FFF, 0, 0); chk("R2 pos odd", 16'(ind), 16'h0001);
    acc_write(16'hFFFE, 0, 0); chk("R2 neg even", 16'(ind), 16'h000A);
    do_cmd(3'd1, 6'h0, '0);
    do_cmd(3'd6, 6'h0, 15'h0010);
    chk("R3 hold", 16'(ind), 16'h000A);
  endtask

  task automatic t_sticky();
    acc_write(16'h0004, 1, 0); chk("R4 carry set", 16'(ind), 16'h0019);
    acc_write(16'h0003, 0, 1); chk("R4 carry sticky, ovf set", 16'(ind), 16'h0031);
    stat_ld = 1; stat_cv = 2'b00; tick();
    chk("R5 status clear", 16'(ind), 16'h0001);
    stat_ld = 1; stat_cv = 2'b10; acc_wr = 1; acc_val = 16'h0001; alu_carry = 1; tick();
    chk("R5 status priority", 16'(ind), 16'h0021);
  endtask

  task automatic t_skip_branch();
    // ind now pos, ovf
    do_cmd(3'd6, 6'h0, 15'h0100);
    chk("R11 jump", 16'(iar), 16'h0100);
    chk("R12 jump taken", 16'(taken), 16'h1);
    do_cmd(3'd3, 6'b000001, '0);
    chk("R6 skip taken", 16'(iar), 16'h0101);
    chk("R12 skip taken", 16'(taken), 16'h1);
    do_cmd(3'd3, 6'b000110, '0);
    chk("R6 skip not taken", 16'(iar), 16'h0101);
    chk("R12 not taken", 16'(taken), 16'h0);
    do_cmd(3'd4, 6'b000010, 15'h0200);
    chk("R7 branch not taken", 16'(iar), 16'h0101);
    do_cmd(3'd4, 6'b100000, 15'h0200);
    chk("R7 branch on ovf", 16'(iar), 16'h0200);
    chk("R8 ovf cleared", 16'(ind), 16'h0001);
    acc_write(16'h0001, 1, 1);
    do_cmd(3'd3, 6'b010100, '0);
    chk("R8 carry cleared", 16'(ind), 16'h0021);
    chk("R6 skip on carry", 16'(iar), 16'h0201);
    do_cmd(3'd4, 6'b010000, 15'h0300);
    chk("R7 cleared carry no branch", 16'(iar), 16'h0201);
  endtask

  task automatic t_mdx();
    mdx_old = 16'h0001; mdx_new = 16'h0000; cmd = 3'd5; tick();
    chk("R9 zero skip", 16'(iar), 16'h0202);
    mdx_old = 16'h0005; mdx_new = 16'h0006; cmd = 3'd5; tick();
    chk("R9 no skip", 16'(iar), 16'h0202);
    chk("R12 mdx not taken", 16'(taken), 16'h0);
    mdx_old = 16'h7FFF; mdx_new = 16'h8000; cmd = 3'd5; tick();
    chk("R9 sign flip", 16'(iar), 16'h0203);
    mdx_old = 16'hFFFF; mdx_new = 16'hFFFE; cmd = 3'd5; tick();
    chk("R9 neg stays neg", 16'(iar), 16'h0203);
  endtask

  task automatic t_wrap();
    do_cmd(3'd6, 6'h0, 15'h7FFF);
    do_cmd(3'd1, 6'h0, '0);
    chk("R10 wrap step1", 16'(iar), 16'h0000);
    do_cmd(3'd2, 6'h0, '0);
    chk("R10 step2", 16'(iar), 16'h0002);
    do_cmd(3'd6, 6'h0, 15'h7FFF);
    do_cmd(3'd2, 6'h0, '0);
    chk("R10 wrap step2", 16'(iar), 16'h0001);
    do_cmd(3'd7, 6'h3F, 15'h1234);
    chk("R10 reserved hold", 16'(iar), 16'h0001);
  endtask

  initial begin
    idle_inputs();
    rst = 1;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    t_reset();
    t_acc_values();
    t_sticky();
    t_skip_branch();
    t_mdx();
    t_wrap();
    done = 1'b1;
  end

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        if (!done) begin
          checks++;
          failures++;
          $display("FAIL watchdog actual=hung expected=done");
        end
      end
      wait (done);
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule